// File: doc/BRIEF.md
# Controller Poll Interval Scheduler

This block decides when the controller channels of a serial controller port are polled. A configuration word supplies lines-per-poll (X), polls-per-frame (Y), a per-channel poll enable and a per-channel "copy only in vertical blank" flag. From these it picks a poll period in system ticks. The period is the shorter of one frame divided by Y and X video lines. When Y is zero it is X lines. When both are zero it is a fixed one-sixtieth-of-a-second tick count. The interval counter restarts at every vsync. Each time the period elapses, the block raises a one-clock poll pulse on every enabled channel at once.

A second path turns a buffer-copy request into per-channel copy strobes. Channels without the vblank flag get their strobe right away. Channels with the flag hold the request until vertical blank. The video timing generator and the device transactions started by a poll are outside the block. Frame length, line length and the fallback period are parameters. The frame/Y quotient comes from a small sequential divider, which runs again only when Y changes.

Top module: `poll_sched`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, `poll_o` and `copy_stb_o` are all zero.
- R2: With Y nonzero, the poll period in counted ticks is min(floor(FRAME_TICKS / Y), X * LINE_TICKS).
- R3: With Y zero and X nonzero, the poll period is X * LINE_TICKS ticks.
- R4: With Y and X both zero, the poll period is SIXTIETH_TICKS ticks.
- R5: A clock with `vsync_i` high clears the interval count, and `poll_o` is zero in the cycle after it. The first poll comes P counted ticks after the last vsync cycle, where P is the period. Only cycles with `tick_i` high are counted.
- R6: A poll is one clock wide and equals the enable mask bit for bit. All enabled channels pulse in the same cycle, and a disabled channel never pulses.
- R7: A channel whose vblank-copy flag is clear pulses its `copy_stb_o` bit for one clock, in the cycle after `copy_req_i`.
- R8: A channel whose vblank-copy flag is set holds a copy request until a clock with `vblank_i` high, then gives one strobe. If the request arrives during vblank, the strobe comes in the next cycle.
- R9: After Y changes, the new quotient is in use within QW+2 clocks (QW = bits of FRAME_TICKS). The quotient is rounded down, and the period is never less than one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | System tick enable; each high cycle counts one tick |
| vsync_i | input | 1 | Vsync strobe; restarts interval counting |
| vblank_i | input | 1 | High during vertical blank |
| cfg_x_i | input | XW (10) | Lines per poll |
| cfg_y_i | input | YW (8) | Polls per frame |
| cfg_en_i | input | NCH (4) | Per-channel poll enable |
| cfg_vbcopy_i | input | NCH (4) | Per-channel copy-only-in-vblank flag |
| copy_req_i | input | 1 | Buffer copy request for all channels |
| poll_o | output | NCH (4) | Per-channel poll pulse |
| copy_stb_o | output | NCH (4) | Per-channel copy strobe |

## Verification
The bench builds the block with LINE_TICKS=10, FRAME_TICKS=600 and SIXTIETH_TICKS=250, so every period is between 2 and 250 clocks. At this scale each selection branch can run through several full periods: the frame/Y term winning, the line term winning, Y zero, both zero, and a quotient as small as two. A vsync in mid-interval can be placed and its restart timed exactly. The 10-step divider also finishes well inside the settling window after each Y change.

// File: rtl/poll_pkg.sv
package poll_pkg;
  function automatic int unsigned umax3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/poll_div.sv
module poll_div #(
  parameter int unsigned DVD = 600,
  parameter int unsigned YW  = 8,
  localparam int unsigned QW = $clog2(DVD + 1),
  localparam int unsigned SW = $clog2(QW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [YW-1:0] y_i,
  output logic [QW-1:0] quot_o
);
  logic [YW-1:0] y_q, y_d;
  logic [YW:0]   rem_q, rem_d, shifted;
  logic [QW-1:0] dq_q, dq_d, quot_q, quot_d;
  logic [SW-1:0] step_q, step_d;
  logic          busy_q, busy_d;

  always_comb begin
    y_d     = y_q;
    rem_d   = rem_q;
    dq_d    = dq_q;
    quot_d  = quot_q;
    step_d  = step_q;
    busy_d  = busy_q;
    shifted = {rem_q[YW-1:0], dq_q[QW-1]};
    if (y_i != y_q) begin
      y_d    = y_i;
      rem_d  = '0;
      dq_d   = QW'(DVD);
      step_d = SW'(QW);
      busy_d = (y_i != '0);
    end else if (busy_q) begin
      if (shifted >= {1'b0, y_q}) begin
        rem_d = shifted - {1'b0, y_q};
        dq_d  = {dq_q[QW-2:0], 1'b1};
      end else begin
        rem_d = shifted;
        dq_d  = {dq_q[QW-2:0], 1'b0};
      end
      step_d = step_q - 1'b1;
      if (step_q == SW'(1)) begin
        busy_d = 1'b0;
        quot_d = dq_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0; rem_q <= '0; dq_q <= '0; quot_q <= '0; step_q <= '0; busy_q <= 1'b0;
    end else begin
      y_q <= y_d; rem_q <= rem_d; dq_q <= dq_d; quot_q <= quot_d;
      step_q <= step_d; busy_q <= busy_d;
    end
  end

  assign quot_o = quot_q;

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && y_q != '0) |->
      ((64'(quot_q) * 64'(y_q) <= 64'(DVD)) &&
       (64'(DVD) < (64'(quot_q) + 64'd1) * 64'(y_q))))
    else $error("quotient not floor of frame/Y"); // R9
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int unsigned NCH = 4,
  parameter int unsigned XW  = 10,
  parameter int unsigned YW  = 8,
  parameter int unsigned QW  = 10,
  parameter int unsigned PW  = 16,
  parameter int unsigned LINE_TICKS     = 10,
  parameter int unsigned SIXTIETH_TICKS = 250
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           vsync_i,
  input  logic [XW-1:0]  x_i,
  input  logic [YW-1:0]  y_i,
  input  logic [NCH-1:0] en_i,
  input  logic [QW-1:0]  quot_i,
  output logic [NCH-1:0] poll_o
);
  logic [PW-1:0]  by_lines, by_frame, raw, period;
  logic [PW-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [NCH-1:0] poll_q, poll_d;
  logic           fire;

  always_comb begin
    by_lines = PW'(x_i) * PW'(LINE_TICKS);
    by_frame = PW'(quot_i);
    if (y_i != '0)      raw = (by_frame < by_lines) ? by_frame : by_lines;
    else if (x_i != '0) raw = by_lines;
    else                raw = PW'(SIXTIETH_TICKS);
    period  = (raw == '0) ? PW'(1) : raw;
    cnt_inc = cnt_q + 1'b1;
    fire    = !vsync_i && tick_i && (cnt_inc >= period);
    if (vsync_i)     cnt_d = '0;
    else if (fire)   cnt_d = '0;
    else if (tick_i) cnt_d = cnt_inc;
    else             cnt_d = cnt_q;
    poll_d = fire ? en_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      poll_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      poll_q <= poll_d;
    end
  end

  assign poll_o = poll_q;

  AST_VSYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (poll_o == '0))
    else $error("poll right after vsync"); // R5
  AST_POLL_MATCHES_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_o != '0) |-> (poll_o == $past(en_i)))
    else $error("poll differs from enable mask"); // R6
endmodule

// File: rtl/poll_copy_gate.sv
module poll_copy_gate #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic           vblank_i,
  input  logic [NCH-1:0] vbcopy_i,
  output logic [NCH-1:0] stb_o
);
  logic [NCH-1:0] pend_q, pend_d, stb_q, stb_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      if (vbcopy_i[i]) begin
        stb_d[i]  = vblank_i && (pend_q[i] || req_i);
        pend_d[i] = !vblank_i && (pend_q[i] || req_i);
      end else begin
        stb_d[i]  = req_i;
        pend_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stb_q  <= '0;
    end else begin
      pend_q <= pend_d;
      stb_q  <= stb_d;
    end
  end

  assign stb_o = stb_q;

  AST_VB_COPY_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb_o & $past(vbcopy_i)) != '0) |-> $past(vblank_i))
    else $error("gated copy outside vblank"); // R8
  AST_COPY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb_o & ~$past(vbcopy_i)) != '0) |-> $past(req_i))
    else $error("ungated copy without request"); // R7
endmodule

// File: rtl/poll_sched.sv
module poll_sched #(
  parameter int unsigned NCH = 4,
  parameter int unsigned XW  = 10,
  parameter int unsigned YW  = 8,
  parameter int unsigned LINE_TICKS     = 640,
  parameter int unsigned FRAME_TICKS    = 336000,
  parameter int unsigned SIXTIETH_TICKS = 405000,
  localparam int unsigned QW = $clog2(FRAME_TICKS + 1),
  localparam int unsigned PW = $clog2(poll_pkg::umax3(FRAME_TICKS,
                                 ((1 << XW) - 1) * LINE_TICKS, SIXTIETH_TICKS) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           vsync_i,
  input  logic           vblank_i,
  input  logic [XW-1:0]  cfg_x_i,
  input  logic [YW-1:0]  cfg_y_i,
  input  logic [NCH-1:0] cfg_en_i,
  input  logic [NCH-1:0] cfg_vbcopy_i,
  input  logic           copy_req_i,
  output logic [NCH-1:0] poll_o,
  output logic [NCH-1:0] copy_stb_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [QW-1:0] quot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  poll_div #(.DVD(FRAME_TICKS), .YW(YW)) u_div (
    .clk(clk), .rst_n(rst_int_n), .y_i(cfg_y_i), .quot_o(quot));

  poll_timer #(.NCH(NCH), .XW(XW), .YW(YW), .QW(QW), .PW(PW),
               .LINE_TICKS(LINE_TICKS), .SIXTIETH_TICKS(SIXTIETH_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick_i), .vsync_i(vsync_i),
    .x_i(cfg_x_i), .y_i(cfg_y_i), .en_i(cfg_en_i), .quot_i(quot), .poll_o(poll_o));

  poll_copy_gate #(.NCH(NCH)) u_copy (
    .clk(clk), .rst_n(rst_int_n), .req_i(copy_req_i), .vblank_i(vblank_i),
    .vbcopy_i(cfg_vbcopy_i), .stb_o(copy_stb_o));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |=> (poll_o == '0 && copy_stb_o == '0))
    else $error("outputs active during reset"); // R1
endmodule

// File: tb/test_poll_sched.sv
module test_poll_sched;
  logic       clk = 1'b0;
  logic       rst_n, tick, vsync, vblank, copy_req;
  logic [9:0] cfg_x;
  logic [7:0] cfg_y;
  logic [3:0] cfg_en, cfg_vbcopy, poll, copy_stb;
  int cyc = 0;
  int vectors = 0, errors = 0;

  int         pq_cyc[$];
  logic [3:0] pq_val[$];
  string      pq_tag[$];
  int         cq_cyc[$];
  logic [3:0] cq_val[$];
  string      cq_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  poll_sched #(.LINE_TICKS(10), .FRAME_TICKS(600), .SIXTIETH_TICKS(250)) i_poll_sched (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .vsync_i(vsync), .vblank_i(vblank),
    .cfg_x_i(cfg_x), .cfg_y_i(cfg_y), .cfg_en_i(cfg_en), .cfg_vbcopy_i(cfg_vbcopy),
    .copy_req_i(copy_req), .poll_o(poll), .copy_stb_o(copy_stb));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  // Monitor: pops expected items as their cycle arrives and compares.
  always @(negedge clk) begin
    if (rst_n) begin
      while (pq_cyc.size() > 0 && pq_cyc[0] < cyc) begin
        check({pq_tag[0], " missed"}, 4'hx, pq_val[0]);
        void'(pq_cyc.pop_front()); void'(pq_val.pop_front()); void'(pq_tag.pop_front());
      end
      if (pq_cyc.size() > 0 && pq_cyc[0] == cyc) begin
        check(pq_tag[0], poll, pq_val[0]);
        void'(pq_cyc.pop_front()); void'(pq_val.pop_front()); void'(pq_tag.pop_front());
      end else if (poll != 4'b0) check("R6 unexpected poll", poll, 4'b0);
      if (cq_cyc.size() > 0 && cq_cyc[0] == cyc) begin
        check(cq_tag[0], copy_stb, cq_val[0]);
        void'(cq_cyc.pop_front()); void'(cq_val.pop_front()); void'(cq_tag.pop_front());
      end else if (copy_stb != 4'b0) check("R7/R8 unexpected copy", copy_stb, 4'b0);
    end
  end

  // Driver: hold vsync while reconfiguring, release, push three expected polls.
  task automatic run_case(input logic [9:0] x, input logic [7:0] y, input logic [3:0] en,
                          input int period, input string tag);
    int c;
    @(negedge clk);
    vsync = 1'b1; cfg_x = x; cfg_y = y; cfg_en = en;
    repeat (30) @(negedge clk);
    c = cyc;
    vsync = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      pq_cyc.push_back(c + k * period); pq_val.push_back(en); pq_tag.push_back(tag);
    end
    repeat (3 * period + 1) @(negedge clk);
    vsync = 1'b1;
  endtask

  initial begin
    int c;
    rst_n = 1'b0; tick = 1'b1; vsync = 1'b1; vblank = 1'b0; copy_req = 1'b0;
    cfg_x = 10'd7; cfg_y = 8'd0; cfg_en = 4'hF; cfg_vbcopy = 4'b0110;
    repeat (3) @(negedge clk);
    check("R1 poll in reset", poll, 4'b0);
    check("R1 copy in reset", copy_stb, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 poll after release", poll, 4'b0);
    repeat (3) @(negedge clk);

    run_case(10'd7, 8'd10,  4'hF,   60, "R2 frame/Y wins");
    run_case(10'd7, 8'd4,   4'hF,   70, "R2 lines win");
    run_case(10'd7, 8'd255, 4'hF,    2, "R9 quotient floor 2");
    run_case(10'd1, 8'd200, 4'b0101, 3, "R6 masked R2 Y=200");
    run_case(10'd7, 8'd0,   4'hF,   70, "R3 Y zero");
    run_case(10'd1, 8'd0,   4'b0000,10, "R6 all disabled R3");
    run_case(10'd0, 8'd0,   4'hF,  250, "R4 fallback");

    // R5: vsync in mid-interval restarts the count
    @(negedge clk);
    cfg_x = 10'd7; cfg_y = 8'd0; cfg_en = 4'b1010;
    repeat (5) @(negedge clk);
    c = cyc; vsync = 1'b0;
    repeat (30) @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    pq_cyc.push_back(c + 31 + 70); pq_val.push_back(4'b1010); pq_tag.push_back("R5 restart");
    repeat (71) @(negedge clk);
    vsync = 1'b1;

    // R7/R8: copy strobes
    @(negedge clk);
    c = cyc; copy_req = 1'b1; vblank = 1'b0;
    cq_cyc.push_back(c + 1); cq_val.push_back(4'b1001); cq_tag.push_back("R7 immediate copy");
    cq_cyc.push_back(c + 5); cq_val.push_back(4'b0110); cq_tag.push_back("R8 deferred copy");
    cq_cyc.push_back(c + 11); cq_val.push_back(4'b1111); cq_tag.push_back("R8 request in vblank");
    @(negedge clk); copy_req = 1'b0;
    repeat (3) @(negedge clk); vblank = 1'b1;
    repeat (2) @(negedge clk); vblank = 1'b0;
    repeat (4) @(negedge clk); vblank = 1'b1; copy_req = 1'b1;
    @(negedge clk); vblank = 1'b0; copy_req = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 no pending left", 4'(cq_cyc.size()), 4'd0);
    check("R5 queue drained", 4'(pq_cyc.size()), 4'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule